// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed running sum in two 32-bit registers, a high word and a low word. On each accepted request it multiplies two signed operands and adds the product into the running sum. Two multiply forms are offered. The long form multiplies the full 32-bit operands. The word form multiplies only the signed low 16 bits of each operand.

A saturation-mode input changes how the sum is written back, and the effect depends on the multiply form. In the long form the high word is limited so that the sum fits in 48 bits. In the word form the sum is clamped to the signed 32-bit range, and the high word is set to 1 to mark that the clamp took place. With saturation off, both forms wrap modulo 2^64.

A clear strobe zeroes the sum. A one-cycle completion pulse follows every accepted request. Both accumulator words can be read at any time.

Top module: `mac_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), acc_hi_o and acc_lo_o read 0 and done_o is 0.
- R2: A long request (op_word_i = 0) sign-extends both full 32-bit operands and adds their 64-bit product into the sum {acc_hi_o, acc_lo_o}. The high word holds the upper 32 bits and the low word the lower 32 bits.
- R3: A word request (op_word_i = 1) sign-extends bits 15:0 of each operand and multiplies those. Bits 31:16 of both operands have no effect on the result.
- R4: With sat_i = 0, both forms write back the full 64-bit sum, wrapping modulo 2^64.
- R5: A long request with sat_i = 1 whose 64-bit sum is negative writes the sum with bits 31:16 of the high word forced to ones. The low word is written unchanged.
- R6: A long request with sat_i = 1 whose 64-bit sum is non-negative writes the sum with bits 31:15 of the high word forced to zero. The low word is written unchanged.
- R7: A word request with sat_i = 1 whose sum is below -2^31 writes 0x80000000 to the low word and 1 to the high word.
- R8: A word request with sat_i = 1 whose sum is above 2^31-1 writes 0x7FFFFFFF to the low word and 1 to the high word.
- R9: A word request with sat_i = 1 whose sum lies within the signed 32-bit range writes the full 64-bit sum back unchanged.
- R10: clear_i at a clock edge zeroes both words. It overrides a start_i request at the same edge, and that request produces no done_o pulse.
- R11: done_o is high for exactly the cycle that follows each edge where start_i is high and clear_i is low. The new sum is visible in that same cycle. With neither start_i nor clear_i, the words hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request valid; accepted at the rising edge |
| op_word_i | input | 1 | 0 = long 32x32 form, 1 = word 16x16 form |
| sat_i | input | 1 | Saturation mode for this request |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand |
| clear_i | input | 1 | Zero the sum; overrides start_i |
| acc_hi_o | output | 32 | Upper 32 bits of the sum |
| acc_lo_o | output | 32 | Lower 32 bits of the sum |
| done_o | output | 1 | One-cycle pulse after an accepted request |

## Verification
The bench builds the unit with its default parameters: 32-bit words, a 16-bit short operand and a 15-bit kept field for the long clamp. With these widths a few operand pairs at the extremes are enough to push the sum across each limit. Repeated (-2^31)x(-2^31) products reach the 2^64 wrap. Repeated 0x7FFF-sized word products cross both signed 32-bit bounds. Single products near 2^62 exercise both long clamps. A behavioural model using 64-bit integers is compared against both words and the pulse on every cycle. This covers directed corner sequences and a run of random requests that mixes clears, idles and both forms.

// File: rtl/mac_pkg.sv
// Package for the multiply-accumulate unit.
// Holds the request-form encoding shared by the design modules.
package mac_pkg;
    typedef enum logic {
        MAC_LONG = 1'b0,
        MAC_WORD = 1'b1
    } mac_form_e;
endpackage

// File: rtl/mac_mult.sv
// Product former: sign-extends the operands according to the request form
// and returns the product truncated to the accumulator width.
// Assumes ACC_W is twice WORD_W. Truncating the product to ACC_W keeps it
// exact modulo 2^ACC_W.
module mac_mult
    import mac_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 16,
    localparam int ACC_W  = 2 * WORD_W
) (
    input  mac_form_e          form_i,
    input  logic [WORD_W-1:0]  a_i,
    input  logic [WORD_W-1:0]  b_i,
    output logic [ACC_W-1:0]   prod_o
);
    logic [ACC_W-1:0] ext_a;
    logic [ACC_W-1:0] ext_b;

    // Choose full-width or short-width sign extension for each operand.
    always_comb begin
        if (form_i == MAC_WORD) begin
            ext_a = {{(ACC_W-SHORT_W){a_i[SHORT_W-1]}}, a_i[SHORT_W-1:0]};
            ext_b = {{(ACC_W-SHORT_W){b_i[SHORT_W-1]}}, b_i[SHORT_W-1:0]};
        end else begin
            ext_a = {{(ACC_W-WORD_W){a_i[WORD_W-1]}}, a_i};
            ext_b = {{(ACC_W-WORD_W){b_i[WORD_W-1]}}, b_i};
        end
    end

    // Product modulo 2^ACC_W; the low bits equal those of the signed product.
    always_comb prod_o = ext_a * ext_b;
endmodule

// File: rtl/mac_sat.sv
// Write-back stage: adds the product into the sum and applies the
// form-specific limit when saturation is requested.
// Assumes the product arrives already sign-extended to ACC_W bits.
module mac_sat
    import mac_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LONG_KEEP = 15,
    localparam int ACC_W    = 2 * WORD_W,
    localparam int TOP_W    = ACC_W - WORD_W + 1
) (
    input  mac_form_e          form_i,
    input  logic               sat_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [ACC_W-1:0]   prod_i,
    output logic [WORD_W-1:0]  hi_o,
    output logic [WORD_W-1:0]  lo_o
);
    localparam logic [WORD_W-1:0] KEEP_MASK = WORD_W'((64'd1 << LONG_KEEP) - 64'd1);
    localparam logic [WORD_W-1:0] NEG_FILL  = ~WORD_W'((64'd1 << (LONG_KEEP + 1)) - 64'd1);
    localparam logic [WORD_W-1:0] POS_LIM   = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_LIM   = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] MARK      = WORD_W'(1);

    logic [ACC_W-1:0] sum;
    logic [TOP_W-1:0] top;
    logic             fits_word;
    logic             neg;

    // Raw wrap-around sum and the range tests on it.
    always_comb begin
        sum       = acc_i + prod_i;
        top       = sum[ACC_W-1:WORD_W-1];
        fits_word = (top == '0) || (top == '1);
        neg       = sum[ACC_W-1];
    end

    // Select the written-back words by form and saturation mode.
    always_comb begin
        hi_o = sum[ACC_W-1:WORD_W];
        lo_o = sum[WORD_W-1:0];
        if (sat_i) begin
            if (form_i == MAC_LONG) begin
                hi_o = neg ? (sum[ACC_W-1:WORD_W] | NEG_FILL)
                           : (sum[ACC_W-1:WORD_W] & KEEP_MASK);
            end else if (!fits_word) begin
                hi_o = MARK;
                lo_o = neg ? NEG_LIM : POS_LIM;
            end
        end
    end
endmodule

// File: rtl/mac_unit.sv
// Saturating multiply-accumulate unit, top level.
// Holds the sum in two word registers and a completion pulse register.
// Assumes a synchronous active-low reset; clear has priority over start.
module mac_unit
    import mac_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SHORT_W   = 16,
    parameter int LONG_KEEP = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_word_i,
    input  logic              sat_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic              clear_i,
    output logic [WORD_W-1:0] acc_hi_o,
    output logic [WORD_W-1:0] acc_lo_o,
    output logic              done_o
);
    localparam int ACC_W = 2 * WORD_W;

    mac_form_e         form;
    logic [ACC_W-1:0]  prod;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] nxt_lo;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] lo_q;
    logic              done_q;

    // Decode the form select into the shared encoding.
    always_comb form = op_word_i ? MAC_WORD : MAC_LONG;

    mac_mult #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W)
    ) u_mult (
        .form_i (form),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (prod)
    );

    mac_sat #(
        .WORD_W    (WORD_W),
        .LONG_KEEP (LONG_KEEP)
    ) u_sat (
        .form_i (form),
        .sat_i  (sat_i),
        .acc_i  ({hi_q, lo_q}),
        .prod_i (prod),
        .hi_o   (nxt_hi),
        .lo_o   (nxt_lo)
    );

    // Sum registers: reset, clear, accept, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (start_i) begin
            hi_q <= nxt_hi;
            lo_q <= nxt_lo;
        end
    end

    // Completion pulse for each request that was not overridden by clear.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= start_i && !clear_i;
    end

    assign acc_hi_o = hi_q;
    assign acc_lo_o = lo_q;
    assign done_o   = done_q;
endmodule

// File: rtl/mac_unit_chk.sv
// Property checker for mac_unit, attached by bind. Observes ports only.
module mac_unit_chk #(
    parameter int WORD_W    = 32,
    parameter int LONG_KEEP = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              op_word_i,
    input logic              sat_i,
    input logic              clear_i,
    input logic [WORD_W-1:0] acc_hi_o,
    input logic [WORD_W-1:0] acc_lo_o,
    input logic              done_o
);
    localparam int HI_FILL = WORD_W - LONG_KEEP - 1;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (acc_hi_o == '0 && acc_lo_o == '0 && !done_o)); // R1

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i) |=> done_o); // R11

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !clear_i) |=> !done_o); // R10

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_hi_o == '0 && acc_lo_o == '0)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !clear_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R11

    AST_LONG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i && !op_word_i && sat_i) |=>
        (acc_hi_o[WORD_W-1 -: HI_FILL] == '1 || acc_hi_o[WORD_W-1:LONG_KEEP] == '0)); // R5 R6

    AST_WORD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i && op_word_i && sat_i) |=>
        (acc_hi_o == '0 || acc_hi_o == '1 || acc_hi_o == WORD_W'(1))); // R7 R8 R9
endmodule

bind mac_unit mac_unit_chk #(
    .WORD_W    (WORD_W),
    .LONG_KEEP (LONG_KEEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_word_i (op_word_i),
    .sat_i     (sat_i),
    .clear_i   (clear_i),
    .acc_hi_o  (acc_hi_o),
    .acc_lo_o  (acc_lo_o),
    .done_o    (done_o)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
// Cycle-by-cycle comparison of mac_unit against a 64-bit integer model.
module mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_word_i = 1'b0;
    logic        sat_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        clear_i = 1'b0;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;
    logic        done_o;

    int     n_vec = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;
    longint m_acc = 0;
    bit     m_done = 1'b0;

    always #2 clk = ~clk;

    mac_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_word_i (op_word_i),
        .sat_i     (sat_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .clear_i   (clear_i),
        .acc_hi_o  (acc_hi_o),
        .acc_lo_o  (acc_lo_o),
        .done_o    (done_o)
    );

    // Behavioural model of one clock edge.
    function automatic void model_edge(bit rst, bit st, bit wd, bit sat,
                                       logic [31:0] a, logic [31:0] b, bit clr);
        longint p, s;
        logic [63:0] v;
        logic [31:0] h;
        if (rst) begin m_acc = 0; m_done = 0; return; end
        m_done = st && !clr;
        if (clr) begin m_acc = 0; return; end
        if (!st) return;
        if (wd) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else    p = longint'($signed(a)) * longint'($signed(b));
        s = m_acc + p;
        v = s;
        if (sat && !wd) begin
            h = v[63:32];
            if (s < 0) h = h | 32'hFFFF_0000;
            else       h = h & 32'h0000_7FFF;
            v = {h, v[31:0]};
        end else if (sat && wd) begin
            if (s < -64'sd2147483648)     v = {32'd1, 32'h8000_0000};
            else if (s > 64'sd2147483647) v = {32'd1, 32'h7FFF_FFFF};
        end
        m_acc = v;
    endfunction

    // Apply one cycle of stimulus, update the model, compare at the falling edge.
    task automatic step(bit st, bit wd, bit sat, logic [31:0] a, logic [31:0] b,
                        bit clr, string tag);
        logic [63:0] e;
        start_i = st; op_word_i = wd; sat_i = sat; opa_i = a; opb_i = b; clear_i = clr;
        @(posedge clk);
        model_edge(!rst_n, st, wd, sat, a, b, clr);
        @(negedge clk);
        e = m_acc;
        n_vec++;
        if ({acc_hi_o, acc_lo_o} !== e || done_o !== m_done) begin
            n_bad++;
            $display("FAIL %s: got hi=%h lo=%h done=%b, expected hi=%h lo=%h done=%b",
                     tag, acc_hi_o, acc_lo_o, done_o, e[63:32], e[31:0], m_done);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        step(1, 0, 0, 32'd5, 32'd7, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");
        // R2: signed long products
        step(1, 0, 0, 32'd3, -32'sd5, 0, "R2");
        step(1, 0, 0, 32'h1234_5678, 32'h0ABC_DEF1, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        // R3: upper operand bits ignored in word form
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 1, 0, 32'hABCD_0003, 32'h5555_FFFE, 0, "R3");
        step(1, 1, 0, 32'hFFFF_8000, 32'h0000_8000, 0, "R3");
        // R4: wrap modulo 2^64
        step(0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, "R4");
        step(1, 1, 0, 32'h7FFF, 32'h7FFF, 0, "R4");
        // R5: long clamp, negative sum
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 0, 1, 32'h8000_0000, 32'h7FFF_FFFF, 0, "R5");
        step(1, 0, 1, -32'sd1, 32'd1, 0, "R5");
        // R6: long clamp, non-negative sum
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R6");
        step(1, 0, 1, 32'd9, 32'd11, 0, "R6");
        // R8: word overflow above 2^31-1
        step(0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 32'h7FFF, 32'h7FFF, 0, "R8");
        // R7: word underflow below -2^31
        step(0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 32'h8000, 32'h7FFF, 0, "R7");
        // R9: in-range word sums written unchanged
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 1, 1, 32'h0000_1234, 32'hFFFF_FF00, 0, "R9");
        step(1, 1, 1, 32'h0000_7FFF, 32'h0000_7FFF, 0, "R9");
        // R10: clear overrides a same-cycle request
        step(1, 0, 0, 32'd100, 32'd100, 0, "R2");
        step(1, 0, 0, 32'd100, 32'd100, 1, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 19);
            step(r != 0 && r < 16, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom, $urandom, r == 0, "R11");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule